// File: doc/BRIEF.md
# TCP Splice Header Rewriter

This block forwards segments of a TCP connection that has already been spliced. Two independent TCP connections, one facing the client and one facing the server, then behave as a single forwarded flow. No protocol stack and no payload copy are involved. Each parsed IPv4/TCP header arrives on a valid/ready stream together with the splice record for its connection. The record comes from a control-block lookup outside this block and carries a hit bit, a sequence offset, an acknowledgement offset, and the replacement addresses and ports.

On a hit, the block replaces the four endpoint fields and shifts the sequence and acknowledgement numbers. It then patches both checksums with the ones-complement incremental update, HC' = ~(~HC + ~m + m'), applied to every changed 16-bit word. The header is never summed from scratch. On a miss, the header leaves on the exception route unchanged. Payload bytes never enter the block.

Two header slots form the pipeline. Slot A holds the captured header and record. Translation and checksum patching run combinationally between the slots. Slot B holds the finished result that drives the outputs. Each slot is a two-state machine with the states SLOT_EMPTY and SLOT_FULL. Its transitions are:
- FILL: SLOT_EMPTY to SLOT_FULL.
- DRAIN: SLOT_FULL to SLOT_EMPTY.
- REFILL: SLOT_FULL to SLOT_FULL, where one header leaves and another enters on the same edge.
- HOLD: the slot stays in its current state.

Slot B drains only when the ready of its own route is high. When slot B cannot drain, slot A cannot move forward, and the input stalls.

Top module: `splice_rewriter`

## Requirements
- R1: After reset, out_valid and exc_miss_valid are low and in_ready is high.
- R2: On a hit, out_seq equals in_seq plus rec_seq_off, modulo 2^32 (wraps past 0xFFFFFFFF).
- R3: On a hit, out_ack equals in_ack minus rec_ack_off, modulo 2^32 (wraps below zero).
- R4: On a hit, the source and destination addresses and ports on the output are the record's values.
- R5: On a hit, out_ip_csum equals the checksum that a full recomputation would give over the new addresses, with all other IP header words unchanged.
- R6: On a hit, out_tcp_csum equals the checksum that a full recomputation would give over the pseudo-header addresses, ports, sequence and acknowledgement numbers, with all other covered words unchanged.
- R7: On a miss (rec_hit low), the header appears with exc_miss_valid high and every output field equal to its input, checksums included.
- R8: out_valid and exc_miss_valid are never high together. Headers leave in the order they were accepted, and each leaves exactly once on the route that matches its hit bit.
- R9: A header accepted on edge k is presented after edge k+1 if nothing stalls. While out_valid is high and out_ready is low, the output holds. With both slots full and slot B blocked, in_ready is low.
- R10: A miss in slot B waits only for exc_ready. While exc_ready is low it stays presented and unchanged, whatever out_ready does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Header and record on the input are valid |
| in_ready | output | 1 | Block accepts the input on this edge |
| in_src_ip | input | 32 | Incoming source address |
| in_dst_ip | input | 32 | Incoming destination address |
| in_src_port | input | 16 | Incoming source port |
| in_dst_port | input | 16 | Incoming destination port |
| in_seq | input | 32 | Incoming sequence number |
| in_ack | input | 32 | Incoming acknowledgement number |
| in_ip_csum | input | 16 | Incoming IP header checksum |
| in_tcp_csum | input | 16 | Incoming TCP checksum |
| rec_hit | input | 1 | Splice record found for this connection |
| rec_seq_off | input | 32 | Offset added to the sequence number |
| rec_ack_off | input | 32 | Offset subtracted from the acknowledgement number |
| rec_src_ip | input | 32 | Replacement source address |
| rec_dst_ip | input | 32 | Replacement destination address |
| rec_src_port | input | 16 | Replacement source port |
| rec_dst_port | input | 16 | Replacement destination port |
| out_ready | input | 1 | Forward route accepts |
| out_valid | output | 1 | Rewritten header presented on the forward route |
| exc_ready | input | 1 | Exception route accepts |
| exc_miss_valid | output | 1 | Unmodified missed header presented on the exception route |
| out_src_ip | output | 32 | Output source address |
| out_dst_ip | output | 32 | Output destination address |
| out_src_port | output | 16 | Output source port |
| out_dst_port | output | 16 | Output destination port |
| out_seq | output | 32 | Output sequence number |
| out_ack | output | 32 | Output acknowledgement number |
| out_ip_csum | output | 16 | Output IP header checksum |
| out_tcp_csum | output | 16 | Output TCP checksum |

## Verification
A slot whose state is wrong shows up directly at the ports:
- A slot stuck in SLOT_FULL repeats or duplicates a header on the next edge that slot B drains.
- A slot stuck in SLOT_EMPTY drops the header, so the ordered scoreboard loses step within two cycles.
- A slot that drains on the wrong route's ready lets a held output change under a low ready. The bench catches this in the very next cycle.

A fault in the translation or checksum logic reaches the output fields two edges after acceptance. The bench compares every departing header against a checksum that it recomputes in full from an independent remainder word.

// File: rtl/splice_pkg.sv
package splice_pkg;

    localparam int ADDR_W = 32;
    localparam int PORT_W = 16;
    localparam int SEQN_W = 32;
    localparam int CSUM_W = 16;

    // 16-bit words that a hit changes under each checksum
    localparam int IP_WORDS  = (2 * ADDR_W) / CSUM_W;
    localparam int TCP_WORDS = (2 * ADDR_W + 2 * PORT_W + 2 * SEQN_W) / CSUM_W;

    typedef struct packed {
        logic [ADDR_W-1:0] src_ip;
        logic [ADDR_W-1:0] dst_ip;
        logic [PORT_W-1:0] src_port;
        logic [PORT_W-1:0] dst_port;
        logic [SEQN_W-1:0] seq;
        logic [SEQN_W-1:0] ack;
        logic [CSUM_W-1:0] ip_csum;
        logic [CSUM_W-1:0] tcp_csum;
    } hdr_t;

    typedef struct packed {
        logic [SEQN_W-1:0] seq_off;
        logic [SEQN_W-1:0] ack_off;
        logic [ADDR_W-1:0] src_ip;
        logic [ADDR_W-1:0] dst_ip;
        logic [PORT_W-1:0] src_port;
        logic [PORT_W-1:0] dst_port;
    } rec_t;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;

endpackage

// File: rtl/csum_patch.sv
module csum_patch
    import splice_pkg::*;
#(
    parameter int N_WORDS = 4
) (
    input  logic [CSUM_W-1:0]         old_csum,
    input  logic [N_WORDS*CSUM_W-1:0] old_w,
    input  logic [N_WORDS*CSUM_W-1:0] new_w,
    output logic [CSUM_W-1:0]         new_csum
);

    // Enough headroom for 2*N_WORDS+1 terms of 16 bits
    localparam int ACC_W = CSUM_W + $clog2(2 * N_WORDS + 2);
    localparam int PAD_W = ACC_W - CSUM_W;

    logic [CSUM_W-1:0] inv_csum;
    logic [ACC_W-1:0]  part [N_WORDS+1];
    logic [CSUM_W:0]   fold1;
    logic [CSUM_W-1:0] fold2;

    assign inv_csum = ~old_csum;
    assign part[0]  = {{PAD_W{1'b0}}, inv_csum};

    for (genvar g = 0; g < N_WORDS; g++) begin : g_term
        logic [CSUM_W-1:0] inv_old;
        logic [CSUM_W-1:0] fresh;
        assign inv_old    = ~old_w[g*CSUM_W +: CSUM_W];
        assign fresh      = new_w[g*CSUM_W +: CSUM_W];
        assign part[g+1]  = part[g] + {{PAD_W{1'b0}}, inv_old}
                                    + {{PAD_W{1'b0}}, fresh};
    end

    // End-around carry, twice, then complement
    assign fold1    = {1'b0, part[N_WORDS][CSUM_W-1:0]}
                    + {{(CSUM_W+1-PAD_W){1'b0}}, part[N_WORDS][ACC_W-1:CSUM_W]};
    assign fold2    = fold1[CSUM_W-1:0] + {{(CSUM_W-1){1'b0}}, fold1[CSUM_W]};
    assign new_csum = ~fold2;

endmodule

// File: rtl/splice_xlate.sv
module splice_xlate
    import splice_pkg::*;
(
    input  hdr_t raw,
    input  rec_t rec,
    input  logic hit,
    output hdr_t nxt
);

    logic [SEQN_W-1:0] seq_new;
    logic [SEQN_W-1:0] ack_new;
    logic [CSUM_W-1:0] ip_c;
    logic [CSUM_W-1:0] tcp_c;
    hdr_t              patched;

    assign seq_new = raw.seq + rec.seq_off;
    assign ack_new = raw.ack - rec.ack_off;

    csum_patch #(.N_WORDS(IP_WORDS)) u_ip_patch (
        .old_csum (raw.ip_csum),
        .old_w    ({raw.src_ip, raw.dst_ip}),
        .new_w    ({rec.src_ip, rec.dst_ip}),
        .new_csum (ip_c)
    );

    csum_patch #(.N_WORDS(TCP_WORDS)) u_tcp_patch (
        .old_csum (raw.tcp_csum),
        .old_w    ({raw.src_ip, raw.dst_ip, raw.src_port, raw.dst_port,
                    raw.seq, raw.ack}),
        .new_w    ({rec.src_ip, rec.dst_ip, rec.src_port, rec.dst_port,
                    seq_new, ack_new}),
        .new_csum (tcp_c)
    );

    always_comb begin
        patched          = raw;
        patched.src_ip   = rec.src_ip;
        patched.dst_ip   = rec.dst_ip;
        patched.src_port = rec.src_port;
        patched.dst_port = rec.dst_port;
        patched.seq      = seq_new;
        patched.ack      = ack_new;
        patched.ip_csum  = ip_c;
        patched.tcp_csum = tcp_c;
        nxt              = hit ? patched : raw;
    end

endmodule

// File: rtl/splice_slot_ctl.sv
module splice_slot_ctl
    import splice_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic b_drain,
    output logic in_ready,
    output logic load_a,
    output logic load_b,
    output logic a_full,
    output logic b_full
);

    slot_e a_st, a_nx;
    slot_e b_st, b_nx;
    logic  b_go;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_st <= SLOT_EMPTY;
            b_st <= SLOT_EMPTY;
        end else begin
            a_st <= a_nx;
            b_st <= b_nx;
        end
    end

    always_comb begin
        b_go     = (b_st == SLOT_FULL) && b_drain;
        load_b   = (a_st == SLOT_FULL) && ((b_st == SLOT_EMPTY) || b_go);
        in_ready = (a_st == SLOT_EMPTY) || load_b;
        load_a   = in_valid && in_ready;
        a_full   = (a_st == SLOT_FULL);
        b_full   = (b_st == SLOT_FULL);

        unique case (a_st)
            SLOT_EMPTY: a_nx = load_a ? SLOT_FULL : SLOT_EMPTY;           // FILL / HOLD
            SLOT_FULL:  a_nx = load_a ? SLOT_FULL                         // REFILL
                             : (load_b ? SLOT_EMPTY : SLOT_FULL);         // DRAIN / HOLD
        endcase

        unique case (b_st)
            SLOT_EMPTY: b_nx = load_b ? SLOT_FULL : SLOT_EMPTY;           // FILL / HOLD
            SLOT_FULL:  b_nx = load_b ? SLOT_FULL                         // REFILL
                             : (b_go ? SLOT_EMPTY : SLOT_FULL);           // DRAIN / HOLD
        endcase
    end

    // R9: an accepted header occupies slot A on the next cycle
    p_accept_fills_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> a_full);

    // R9: slot B only becomes occupied from an occupied slot A
    p_b_from_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_full) |-> $past(a_full));

    // R9: a blocked full pipeline refuses input
    p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        a_full && b_full && !b_drain |=> $past(!in_ready));

endmodule

// File: rtl/splice_rewriter.sv
module splice_rewriter
    import splice_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_src_ip,
    input  logic [ADDR_W-1:0] in_dst_ip,
    input  logic [PORT_W-1:0] in_src_port,
    input  logic [PORT_W-1:0] in_dst_port,
    input  logic [SEQN_W-1:0] in_seq,
    input  logic [SEQN_W-1:0] in_ack,
    input  logic [CSUM_W-1:0] in_ip_csum,
    input  logic [CSUM_W-1:0] in_tcp_csum,
    input  logic              rec_hit,
    input  logic [SEQN_W-1:0] rec_seq_off,
    input  logic [SEQN_W-1:0] rec_ack_off,
    input  logic [ADDR_W-1:0] rec_src_ip,
    input  logic [ADDR_W-1:0] rec_dst_ip,
    input  logic [PORT_W-1:0] rec_src_port,
    input  logic [PORT_W-1:0] rec_dst_port,
    input  logic              out_ready,
    output logic              out_valid,
    input  logic              exc_ready,
    output logic              exc_miss_valid,
    output logic [ADDR_W-1:0] out_src_ip,
    output logic [ADDR_W-1:0] out_dst_ip,
    output logic [PORT_W-1:0] out_src_port,
    output logic [PORT_W-1:0] out_dst_port,
    output logic [SEQN_W-1:0] out_seq,
    output logic [SEQN_W-1:0] out_ack,
    output logic [CSUM_W-1:0] out_ip_csum,
    output logic [CSUM_W-1:0] out_tcp_csum
);

    hdr_t in_hdr, a_hdr, b_hdr, xl_hdr;
    rec_t in_rec, a_rec;
    logic a_hit, b_hit;
    logic load_a, load_b, a_full, b_full, b_drain;

    assign in_hdr = '{src_ip: in_src_ip, dst_ip: in_dst_ip,
                      src_port: in_src_port, dst_port: in_dst_port,
                      seq: in_seq, ack: in_ack,
                      ip_csum: in_ip_csum, tcp_csum: in_tcp_csum};
    assign in_rec = '{seq_off: rec_seq_off, ack_off: rec_ack_off,
                      src_ip: rec_src_ip, dst_ip: rec_dst_ip,
                      src_port: rec_src_port, dst_port: rec_dst_port};

    // Slot B drains on the ready of its own route only
    assign b_drain = b_hit ? out_ready : exc_ready;

    splice_slot_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .b_drain  (b_drain),
        .in_ready (in_ready),
        .load_a   (load_a),
        .load_b   (load_b),
        .a_full   (a_full),
        .b_full   (b_full)
    );

    splice_xlate u_xlate (
        .raw (a_hdr),
        .rec (a_rec),
        .hit (a_hit),
        .nxt (xl_hdr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_hdr <= '0;
            a_rec <= '0;
            a_hit <= 1'b0;
            b_hdr <= '0;
            b_hit <= 1'b0;
        end else begin
            if (load_a) begin
                a_hdr <= in_hdr;
                a_rec <= in_rec;
                a_hit <= rec_hit;
            end
            if (load_b) begin
                b_hdr <= xl_hdr;
                b_hit <= a_hit;
            end
        end
    end

    always_comb begin
        out_valid      = b_full && b_hit;
        exc_miss_valid = b_full && !b_hit;
        out_src_ip     = b_hdr.src_ip;
        out_dst_ip     = b_hdr.dst_ip;
        out_src_port   = b_hdr.src_port;
        out_dst_port   = b_hdr.dst_port;
        out_seq        = b_hdr.seq;
        out_ack        = b_hdr.ack;
        out_ip_csum    = b_hdr.ip_csum;
        out_tcp_csum   = b_hdr.tcp_csum;
    end

    // R9: a stalled forward output holds its content
    p_hold_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_seq)
                                    && $stable(out_tcp_csum) && $stable(out_src_ip));

    // R10: a stalled miss stays presented, regardless of out_ready
    p_hold_exc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_miss_valid && !exc_ready |=> exc_miss_valid && $stable(out_seq)
                                         && $stable(out_ip_csum));

endmodule

// File: tb/splice_rewriter_test.sv
module splice_rewriter_test;
    import splice_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    hdr_t drv_h;
    rec_t drv_r;
    logic drv_hit, in_valid, out_ready, exc_ready;
    logic in_ready, out_valid, exc_miss_valid;
    logic [31:0] o_src_ip, o_dst_ip, o_seq, o_ack;
    logic [15:0] o_src_port, o_dst_port, o_ip_csum, o_tcp_csum;

    int   checks = 0;
    int   fails  = 0;
    bit   done = 0;
    bit   rand_rdy = 0;
    hdr_t exp_q[$];
    bit   hit_q[$];
    hdr_t pend_e;
    bit   pend_hit;
    bit   last_fire_in;
    bit   held_out = 0, held_exc = 0;
    logic [31:0] held_seq;

    splice_rewriter uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_src_ip(drv_h.src_ip), .in_dst_ip(drv_h.dst_ip),
        .in_src_port(drv_h.src_port), .in_dst_port(drv_h.dst_port),
        .in_seq(drv_h.seq), .in_ack(drv_h.ack),
        .in_ip_csum(drv_h.ip_csum), .in_tcp_csum(drv_h.tcp_csum),
        .rec_hit(drv_hit), .rec_seq_off(drv_r.seq_off), .rec_ack_off(drv_r.ack_off),
        .rec_src_ip(drv_r.src_ip), .rec_dst_ip(drv_r.dst_ip),
        .rec_src_port(drv_r.src_port), .rec_dst_port(drv_r.dst_port),
        .out_ready(out_ready), .out_valid(out_valid),
        .exc_ready(exc_ready), .exc_miss_valid(exc_miss_valid),
        .out_src_ip(o_src_ip), .out_dst_ip(o_dst_ip),
        .out_src_port(o_src_port), .out_dst_port(o_dst_port),
        .out_seq(o_seq), .out_ack(o_ack),
        .out_ip_csum(o_ip_csum), .out_tcp_csum(o_tcp_csum)
    );

    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'b0, s[16]};
    endfunction

    // Full ones-complement sum: remainder word plus the words a hit may change
    function automatic logic [15:0] ip_sum(input logic [15:0] rem, input hdr_t h);
        logic [15:0] s;
        s = oc_add(rem, h.src_ip[31:16]);
        s = oc_add(s, h.src_ip[15:0]);
        s = oc_add(s, h.dst_ip[31:16]);
        return oc_add(s, h.dst_ip[15:0]);
    endfunction

    function automatic logic [15:0] tcp_sum(input logic [15:0] rem, input hdr_t h);
        logic [15:0] s;
        s = ip_sum(rem, h);
        s = oc_add(s, h.src_port);
        s = oc_add(s, h.dst_port);
        s = oc_add(s, h.seq[31:16]);
        s = oc_add(s, h.seq[15:0]);
        s = oc_add(s, h.ack[31:16]);
        return oc_add(s, h.ack[15:0]);
    endfunction

    function automatic hdr_t rnd_hdr();
        hdr_t h;
        h.src_ip = $urandom; h.dst_ip = $urandom;
        h.src_port = 16'($urandom); h.dst_port = 16'($urandom);
        h.seq = $urandom; h.ack = $urandom;
        h.ip_csum = '0; h.tcp_csum = '0;
        return h;
    endfunction

    function automatic rec_t rnd_rec();
        rec_t r;
        r.seq_off = $urandom; r.ack_off = $urandom;
        r.src_ip = $urandom; r.dst_ip = $urandom;
        r.src_port = 16'($urandom); r.dst_port = 16'($urandom);
        return r;
    endfunction

    // Gives the header consistent checksums and derives the expected output
    task automatic build(input hdr_t base, input rec_t r, input bit hit,
                         output hdr_t h, output hdr_t e);
        logic [15:0] r_ip, r_tcp;
        r_ip  = 16'($urandom_range(1, 65535));
        r_tcp = 16'($urandom_range(1, 65535));
        h = base;
        h.ip_csum  = ~ip_sum(r_ip, h);
        h.tcp_csum = ~tcp_sum(r_tcp, h);
        e = h;
        if (hit) begin
            e.src_ip = r.src_ip; e.dst_ip = r.dst_ip;
            e.src_port = r.src_port; e.dst_port = r.dst_port;
            e.seq = h.seq + r.seq_off;
            e.ack = h.ack - r.ack_off;
            e.ip_csum  = ~ip_sum(r_ip, e);
            e.tcp_csum = ~tcp_sum(r_tcp, e);
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmp_out(input bit hit, input hdr_t e);
        chk(hit ? "R4 src_ip"   : "R7 src_ip",   o_src_ip,   e.src_ip);
        chk(hit ? "R4 dst_ip"   : "R7 dst_ip",   o_dst_ip,   e.dst_ip);
        chk(hit ? "R4 src_port" : "R7 src_port", 32'(o_src_port), 32'(e.src_port));
        chk(hit ? "R4 dst_port" : "R7 dst_port", 32'(o_dst_port), 32'(e.dst_port));
        chk(hit ? "R2 seq"      : "R7 seq",      o_seq,      e.seq);
        chk(hit ? "R3 ack"      : "R7 ack",      o_ack,      e.ack);
        chk(hit ? "R5 ip_csum"  : "R7 ip_csum",  32'(o_ip_csum),  32'(e.ip_csum));
        chk(hit ? "R6 tcp_csum" : "R7 tcp_csum", 32'(o_tcp_csum), 32'(e.tcp_csum));
    endtask

    // One cycle: starts at a falling edge, samples 1 time unit later
    task automatic step();
        bit fi, fo, fe, eh;
        hdr_t ex;
        if (rand_rdy) begin
            out_ready = ($urandom % 4) != 0;
            exc_ready = ($urandom % 3) != 0;
        end
        #1;
        if (held_out) begin
            chk("R9 stalled out_valid", 32'(out_valid), 32'd1);
            chk("R9 stalled out_seq", o_seq, held_seq);
        end
        if (held_exc) begin
            chk("R10 stalled exc_miss_valid", 32'(exc_miss_valid), 32'd1);
            chk("R10 stalled out_seq", o_seq, held_seq);
        end
        if (out_valid && exc_miss_valid)
            chk("R8 routes exclusive", 32'd1, 32'd0);
        fi = in_valid && in_ready;
        fo = out_valid && out_ready;
        fe = exc_miss_valid && exc_ready;
        if (fo || fe) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected departure", 32'd1, 32'd0);
            end else begin
                ex = exp_q.pop_front();
                eh = hit_q.pop_front();
                chk("R8 route matches hit", 32'(fo), 32'(eh));
                cmp_out(eh, ex);
            end
        end
        if (fi) begin
            exp_q.push_back(pend_e);
            hit_q.push_back(pend_hit);
        end
        held_out = out_valid && !out_ready;
        held_exc = exc_miss_valid && !exc_ready;
        held_seq = o_seq;
        last_fire_in = fi;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic present(input hdr_t h, input rec_t r, input bit hit, input hdr_t e);
        drv_h = h; drv_r = r; drv_hit = hit;
        pend_e = e; pend_hit = hit;
        in_valid = 1'b1;
    endtask

    task automatic send(input hdr_t h, input rec_t r, input bit hit, input hdr_t e);
        present(h, r, hit, e);
        do step(); while (!last_fire_in);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        rand_rdy = 0;
        out_ready = 1'b1;
        exc_ready = 1'b1;
        for (int i = 0; i < 50 && exp_q.size() != 0; i++) step();
        chk("R8 every header delivered", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        hdr_t h, e, b;
        rec_t r;
        void'($urandom(32'd7321));
        in_valid = 1'b0; out_ready = 1'b1; exc_ready = 1'b1;
        drv_h = '0; drv_r = '0; drv_hit = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R1 exc_miss_valid after reset", 32'(exc_miss_valid), 32'd0);
        chk("R1 in_ready after reset", 32'(in_ready), 32'd1);
        @(negedge clk);

        // R9 latency: accepted on edge k, visible after edge k+1
        r = rnd_rec();
        build(rnd_hdr(), r, 1'b1, h, e);
        send(h, r, 1'b1, e);
        #1 chk("R9 not visible after one edge", 32'(out_valid), 32'd0);
        step();
        #1 chk("R9 visible after two edges", 32'(out_valid), 32'd1);
        drain();

        // R2 and R3 wrap corners
        b = rnd_hdr(); r = rnd_rec();
        b.seq = 32'hFFFF_FFF0; r.seq_off = 32'h0000_0020;
        b.ack = 32'h0000_0005; r.ack_off = 32'h0000_000A;
        build(b, r, 1'b1, h, e);
        send(h, r, 1'b1, e);
        drain();

        // R7 miss passes untouched on the exception route
        r = rnd_rec();
        build(rnd_hdr(), r, 1'b0, h, e);
        send(h, r, 1'b0, e);
        drain();

        // R9 full stall: both slots occupied, nothing drains
        out_ready = 1'b0; exc_ready = 1'b0;
        for (int i = 0; i < 2; i++) begin
            r = rnd_rec();
            build(rnd_hdr(), r, 1'b1, h, e);
            send(h, r, 1'b1, e);
        end
        r = rnd_rec();
        build(rnd_hdr(), r, 1'b1, h, e);
        present(h, r, 1'b1, e);
        repeat (3) begin
            #1 chk("R9 in_ready low when full", 32'(in_ready), 32'd0);
            step();
        end
        out_ready = 1'b1;
        send(h, r, 1'b1, e);
        drain();

        // R10: a miss waits for exc_ready even with out_ready high
        out_ready = 1'b1; exc_ready = 1'b0;
        r = rnd_rec();
        build(rnd_hdr(), r, 1'b0, h, e);
        send(h, r, 1'b0, e);
        r = rnd_rec();
        build(rnd_hdr(), r, 1'b1, h, e);
        send(h, r, 1'b1, e);
        repeat (3) step();
        #1 chk("R10 miss still presented", 32'(exc_miss_valid), 32'd1);
        chk("R8 hit held behind miss", 32'(out_valid), 32'd0);
        drain();

        // Random traffic with random readies
        rand_rdy = 1;
        for (int n = 0; n < N_RANDOM; n++) begin
            bit hit;
            hit = ($urandom % 5) != 0;
            r = rnd_rec();
            build(rnd_hdr(), r, hit, h, e);
            send(h, r, hit, e);
        end
        drain();

        done = 1;
        summary();
        $finish;
    end

endmodule